// File: doc/BRIEF.md
# Audio Samplestamp Generator

This block places audio frames on a time axis defined by a fast reference clock. The reference clock clocks the block. A sub-period counter measures how many reference cycles have passed since the latest rising word-clock edge. A frame counter counts word-clock edges modulo a programmable buffer length. Together the two counters give a sample position with a fractional part.

An event pulse captures both counters, so software can stamp an external event against the audio stream. The block reports the length of the most recent word-clock period. It also keeps the shortest period seen, which shows up spurious word-clock pulses. Software can move the frame counter with an absolute set command or a relative add command. Two one-shot triggers start the input and output streams when the frame counter reaches a programmed compare value.

The word clock arrives already synchronized to the reference clock. All configuration and command writes share one data bus, and each write has its own strobe.

Top module: `sstamp_top`

## Requirements
- R1: The sub-period counter increments every reference cycle and returns to 0 in the cycle after each rising word-clock edge. From the second rising edge after enable onward, each edge loads `periodOut` with the counter value plus one, which is the number of cycles between the last two edges. The first edge after enable loads nothing.
- R2: The frame counter advances by one on each rising word-clock edge modulo the programmed modulus. A modulus of 0 means 2^CNT_W.
- R3: An event pulse while enabled copies the current sub-period count to `captRef` and the current frame count to `captWord`, both taken before that cycle's update.
- R4: While `enable` is low, the counters, period, captures, latched count, ready flags and start pulses are held at 0, and the minimum period is held at all ones. Commands are ignored during this time. Reset gives the same state.
- R5: A set command loads the frame counter with the written value. A rising edge in the same cycle adds one on top of that value.
- R6: An add command adds the written value to the frame counter modulo the modulus. A rising edge in the same cycle is also counted, so the counter changes by value+1 (for example 4 + 3 + 1 with modulus 5 gives 3).
- R7: Each period measurement replaces `minPeriod` only if the new period is smaller. A minimum-reset write sets it to all ones, whatever data is on the bus.
- R8: An arm strobe raises a stream's ready flag. While the flag is high and the frame counter equals that stream's compare value, the next cycle drops the flag and gives exactly one start pulse. If the flag is already high and the counter matches, the match wins over an arm in the same cycle.
- R9: A read strobe latches the sub-period count into `refLatched` in the same clock edge, so it can be read together with the frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low clears its state |
| wordClk | input | 1 | Synchronized word clock level |
| eventPulse | input | 1 | Capture request |
| wrData | input | CNT_W | Shared write data |
| wrModulus | input | 1 | Write frame modulus |
| wrInTrig | input | 1 | Write input-stream compare value |
| wrOutTrig | input | 1 | Write output-stream compare value |
| wrSet | input | 1 | Set frame counter |
| wrAdd | input | 1 | Add to frame counter |
| wrMinReset | input | 1 | Reset minimum period to all ones |
| rdWordCnt | input | 1 | Latch sub-period count for a consistent read |
| armIn | input | 1 | Arm input-stream start |
| armOut | input | 1 | Arm output-stream start |
| refCount | output | CNT_W | Live sub-period count |
| refLatched | output | CNT_W | Sub-period count latched by read strobe |
| wordCount | output | CNT_W | Live frame count |
| periodOut | output | CNT_W | Last measured word-clock period |
| minPeriod | output | CNT_W | Smallest measured period |
| captRef | output | CNT_W | Captured sub-period count |
| captWord | output | CNT_W | Captured frame count |
| inReady | output | 1 | Input-stream start armed |
| outReady | output | 1 | Output-stream start armed |
| inStart | output | 1 | One-cycle input-stream start |
| outStart | output | 1 | One-cycle output-stream start |

## Verification
The bench builds the block with CNT_W = 8. With that width, a modulus of 0 stands for 256, and the frame counter can wrap at the full counter width within a few hundred word-clock edges. The all-ones minimum value is 255. A word-clock period only a few cycles long still exercises the compare between period and minimum. The narrow counters also make it likely that random set and add values run into the modular reduction.

// File: rtl/sstamp_pkg.sv
package sstamp_pkg;
  typedef struct packed {
    logic clear;
    logic edgeHit;
    logic measure;
    logic setCnt;
    logic addCnt;
    logic capture;
    logic latchRef;
    logic minReset;
  } stampStrobe_t;
endpackage

// File: rtl/sstamp_ctrl.sv
module sstamp_ctrl
  import sstamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wordClk,
  input  logic             eventPulse,
  input  logic [CNT_W-1:0] wrData,
  input  logic             wrInTrig,
  input  logic             wrOutTrig,
  input  logic             wrSet,
  input  logic             wrAdd,
  input  logic             wrMinReset,
  input  logic             rdWordCnt,
  input  logic             armIn,
  input  logic             armOut,
  input  logic [CNT_W-1:0] wordCnt,
  output stampStrobe_t     strobe,
  output logic             inReady,
  output logic             outReady,
  output logic             inStart,
  output logic             outStart
);
  localparam int NSTREAM = 2;

  logic wordClkD;
  logic seenEdge;
  logic riseHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordClkD <= 1'b0;
    else       wordClkD <= wordClk;
  end

  assign riseHit = wordClk & ~wordClkD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        seenEdge <= 1'b0;
    else if (!enable) seenEdge <= 1'b0;
    else if (riseHit) seenEdge <= 1'b1;
  end

  always_comb begin
    strobe.clear    = ~enable;
    strobe.edgeHit  = enable & riseHit;
    strobe.measure  = enable & riseHit & seenEdge;
    strobe.setCnt   = enable & wrSet;
    strobe.addCnt   = enable & wrAdd;
    strobe.capture  = enable & eventPulse;
    strobe.latchRef = enable & rdWordCnt;
    strobe.minReset = wrMinReset;
  end

  logic [NSTREAM-1:0] armVec, wrTrigVec, readyVec, startVec;
  assign armVec    = {armOut, armIn};
  assign wrTrigVec = {wrOutTrig, wrInTrig};

  for (genvar g = 0; g < NSTREAM; g++) begin : g_stream
    logic [CNT_W-1:0] trigReg;
    logic             hit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             trigReg <= '0;
      else if (wrTrigVec[g]) trigReg <= wrData;
    end

    assign hit = readyVec[g] && (wordCnt == trigReg);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        readyVec[g] <= 1'b0;
        startVec[g] <= 1'b0;
      end else if (!enable) begin
        readyVec[g] <= 1'b0;
        startVec[g] <= 1'b0;
      end else begin
        startVec[g] <= 1'b0;
        if (hit) begin
          readyVec[g] <= 1'b0;
          startVec[g] <= 1'b1;
        end else if (armVec[g]) begin
          readyVec[g] <= 1'b1;
        end
      end
    end

    // R8: a start pulse lasts one cycle
    p_start_oneshot_r8: assert property (@(posedge clk) disable iff (!rstN)
      startVec[g] |=> !startVec[g]);

    // R8: a match on an armed stream drops ready and fires start
    p_ready_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
      (enable && readyVec[g] && (wordCnt == trigReg)) |=> (!readyVec[g] && startVec[g]));

    // R4: disable clears the stream state
    p_stream_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
      !enable |=> (!readyVec[g] && !startVec[g]));
  end

  assign inReady  = readyVec[0];
  assign outReady = readyVec[1];
  assign inStart  = startVec[0];
  assign outStart = startVec[1];
endmodule

// File: rtl/sstamp_dp.sv
module sstamp_dp
  import sstamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stampStrobe_t     strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic             wrModulus,
  output logic [CNT_W-1:0] refCnt,
  output logic [CNT_W-1:0] wordCnt,
  output logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] minPeriod,
  output logic [CNT_W-1:0] captRef,
  output logic [CNT_W-1:0] captWord,
  output logic [CNT_W-1:0] refLatched
);
  localparam int SW = CNT_W + 2;

  logic [CNT_W-1:0] modReg;
  logic [CNT_W:0]   modFull;
  logic [CNT_W-1:0] baseVal;
  logic [CNT_W-1:0] nextPeriod;
  logic [SW-1:0]    sumRaw, sumRed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          modReg <= '0;
    else if (wrModulus) modReg <= wrData;
  end

  assign modFull    = (modReg == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, modReg};
  assign baseVal    = strobe.setCnt ? wrData : wordCnt;
  assign sumRaw     = SW'(baseVal) + SW'(strobe.edgeHit) + (strobe.addCnt ? SW'(wrData) : SW'(0));
  assign sumRed     = (sumRaw >= SW'(modFull)) ? (sumRaw - SW'(modFull)) : sumRaw;
  assign nextPeriod = refCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0; wordCnt <= '0; periodVal <= '0;
    end else if (strobe.clear) begin
      refCnt <= '0; wordCnt <= '0; periodVal <= '0;
    end else begin
      refCnt <= strobe.edgeHit ? '0 : nextPeriod;
      if (strobe.measure) periodVal <= nextPeriod;
      if (strobe.edgeHit || strobe.setCnt || strobe.addCnt) wordCnt <= sumRed[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 minPeriod <= '1;
    else if (strobe.clear || strobe.minReset)  minPeriod <= '1;
    else if (strobe.measure && (nextPeriod < minPeriod)) minPeriod <= nextPeriod;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captRef <= '0; captWord <= '0; refLatched <= '0;
    end else if (strobe.clear) begin
      captRef <= '0; captWord <= '0; refLatched <= '0;
    end else begin
      if (strobe.capture) begin
        captRef  <= refCnt;
        captWord <= wordCnt;
      end
      if (strobe.latchRef) refLatched <= refCnt;
    end
  end

  // R1: the sub-period counter restarts after a rising edge
  p_ref_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.edgeHit && !strobe.clear) |=> (refCnt == '0));

  // R7: after a measurement the minimum never exceeds the new period
  p_min_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.measure && !strobe.minReset) |=> (minPeriod <= periodVal));

  // R4: clearing empties counters and captures
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (refCnt == '0 && wordCnt == '0 && captRef == '0 && captWord == '0 && minPeriod == '1));

  // R9: the latched value is the count seen at the read strobe
  p_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchRef && !strobe.clear) |=> (refLatched == $past(refCnt)));

  // R3: the capture holds the frame count seen at the event
  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.clear) |=> (captWord == $past(wordCnt)));
endmodule

// File: rtl/sstamp_top.sv
module sstamp_top
  import sstamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wordClk,
  input  logic             eventPulse,
  input  logic [CNT_W-1:0] wrData,
  input  logic             wrModulus,
  input  logic             wrInTrig,
  input  logic             wrOutTrig,
  input  logic             wrSet,
  input  logic             wrAdd,
  input  logic             wrMinReset,
  input  logic             rdWordCnt,
  input  logic             armIn,
  input  logic             armOut,
  output logic [CNT_W-1:0] refCount,
  output logic [CNT_W-1:0] refLatched,
  output logic [CNT_W-1:0] wordCount,
  output logic [CNT_W-1:0] periodOut,
  output logic [CNT_W-1:0] minPeriod,
  output logic [CNT_W-1:0] captRef,
  output logic [CNT_W-1:0] captWord,
  output logic             inReady,
  output logic             outReady,
  output logic             inStart,
  output logic             outStart
);
  stampStrobe_t strobe;

  sstamp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .wordClk(wordClk),
    .eventPulse(eventPulse), .wrData(wrData), .wrInTrig(wrInTrig),
    .wrOutTrig(wrOutTrig), .wrSet(wrSet), .wrAdd(wrAdd),
    .wrMinReset(wrMinReset), .rdWordCnt(rdWordCnt), .armIn(armIn),
    .armOut(armOut), .wordCnt(wordCount), .strobe(strobe),
    .inReady(inReady), .outReady(outReady), .inStart(inStart),
    .outStart(outStart)
  );

  sstamp_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .wrModulus(wrModulus), .refCnt(refCount), .wordCnt(wordCount),
    .periodVal(periodOut), .minPeriod(minPeriod), .captRef(captRef),
    .captWord(captWord), .refLatched(refLatched)
  );
endmodule

// File: tb/sim_sstamp_top.sv
`timescale 1ns/1ps
module sim_sstamp_top;
  localparam int TW = 8;
  localparam int ONES = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, wordClk = 1'b0, eventPulse = 1'b0;
  logic [TW-1:0] wrData = '0;
  logic wrModulus = 0, wrInTrig = 0, wrOutTrig = 0, wrSet = 0, wrAdd = 0;
  logic wrMinReset = 0, rdWordCnt = 0, armIn = 0, armOut = 0;
  logic [TW-1:0] refCount, refLatched, wordCount, periodOut, minPeriod, captRef, captWord;
  logic inReady, outReady, inStart, outStart;

  int nChecks = 0, nFail = 0, nInStart = 0, nOutStart = 0;
  int unsigned seedVal;

  always #2.5 clk = ~clk;

  sstamp_top #(.CNT_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .wordClk(wordClk),
    .eventPulse(eventPulse), .wrData(wrData), .wrModulus(wrModulus),
    .wrInTrig(wrInTrig), .wrOutTrig(wrOutTrig), .wrSet(wrSet), .wrAdd(wrAdd),
    .wrMinReset(wrMinReset), .rdWordCnt(rdWordCnt), .armIn(armIn), .armOut(armOut),
    .refCount(refCount), .refLatched(refLatched), .wordCount(wordCount),
    .periodOut(periodOut), .minPeriod(minPeriod), .captRef(captRef),
    .captWord(captWord), .inReady(inReady), .outReady(outReady),
    .inStart(inStart), .outStart(outStart)
  );

  // reference model state, derived from the requirements
  int mWcD, mSeen, mRef, mPer, mMin, mWord, mCapR, mCapW, mLat;
  int mInRdy, mOutRdy, mInSt, mOutSt, mModReg, mInTrig, mOutTrig;

  function automatic int modOf(int r);
    return (r == 0) ? (1 << TW) : r;
  endfunction

  function automatic int wordNext(int word, int modR, bit setC, bit addC, bit rise, int data);
    int s;
    s = (setC ? data : word) + (rise ? 1 : 0) + (addC ? data : 0);
    if (s >= modOf(modR)) s = s - modOf(modR);
    return s;
  endfunction

  always @(posedge clk or negedge rstN) begin : mdl
    int np, nw;
    bit rise, inHit, outHit;
    if (!rstN) begin
      mWcD = 0; mSeen = 0; mRef = 0; mPer = 0; mMin = ONES; mWord = 0;
      mCapR = 0; mCapW = 0; mLat = 0; mInRdy = 0; mOutRdy = 0; mInSt = 0;
      mOutSt = 0; mModReg = 0; mInTrig = 0; mOutTrig = 0;
    end else begin
      rise = wordClk && (mWcD == 0);
      if (!enable) begin
        mSeen = 0; mRef = 0; mPer = 0; mMin = ONES; mWord = 0; mCapR = 0;
        mCapW = 0; mLat = 0; mInRdy = 0; mOutRdy = 0; mInSt = 0; mOutSt = 0;
      end else begin
        np = (mRef + 1) % (1 << TW);
        if (eventPulse) begin mCapR = mRef; mCapW = mWord; end
        if (rdWordCnt) mLat = mRef;
        inHit = (mInRdy != 0) && (mWord == mInTrig);
        outHit = (mOutRdy != 0) && (mWord == mOutTrig);
        mInSt = inHit ? 1 : 0;
        mOutSt = outHit ? 1 : 0;
        if (inHit) mInRdy = 0; else if (armIn) mInRdy = 1;
        if (outHit) mOutRdy = 0; else if (armOut) mOutRdy = 1;
        if (rise && mSeen != 0) mPer = np;
        if (wrMinReset) mMin = ONES;
        else if (rise && mSeen != 0 && np < mMin) mMin = np;
        if (rise || wrSet || wrAdd) begin
          nw = wordNext(mWord, mModReg, wrSet, wrAdd, rise, int'(wrData));
          mWord = nw;
        end
        mRef = rise ? 0 : np;
        if (rise) mSeen = 1;
      end
      if (wrModulus) mModReg = int'(wrData);
      if (wrInTrig) mInTrig = int'(wrData);
      if (wrOutTrig) mOutTrig = int'(wrData);
      mWcD = wordClk ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (inStart) nInStart++;
    if (outStart) nOutStart++;
  end

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmpAll(string tag);
    chk(tag, "refCount", int'(refCount), mRef);
    chk(tag, "refLatched", int'(refLatched), mLat);
    chk(tag, "wordCount", int'(wordCount), mWord);
    chk(tag, "periodOut", int'(periodOut), mPer);
    chk(tag, "minPeriod", int'(minPeriod), mMin);
    chk(tag, "captRef", int'(captRef), mCapR);
    chk(tag, "captWord", int'(captWord), mCapW);
    chk(tag, "inReady", int'(inReady), mInRdy);
    chk(tag, "outReady", int'(outReady), mOutRdy);
    chk(tag, "inStart", int'(inStart), mInSt);
    chk(tag, "outStart", int'(outStart), mOutSt);
  endtask

  task automatic clearCmds();
    eventPulse = 0; wrModulus = 0; wrInTrig = 0; wrOutTrig = 0; wrSet = 0;
    wrAdd = 0; wrMinReset = 0; rdWordCnt = 0; armIn = 0; armOut = 0;
  endtask

  task automatic tickc(string tag);
    @(posedge clk);
    @(negedge clk);
    clearCmds();
    cmpAll(tag);
  endtask

  task automatic runClk(string tag, int half, int edges);
    for (int e = 0; e < edges; e++) begin
      wordClk = 1;
      for (int h = 0; h < half; h++) tickc(tag);
      wordClk = 0;
      for (int h = 0; h < half; h++) tickc(tag);
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin : main
    int a, b, s0, s1;
    seedVal = $urandom(32'd4242);
    @(negedge clk);
    @(negedge clk);
    // R4: reset state
    chk("R4", "reset wordCount", int'(wordCount), 0);
    chk("R4", "reset minPeriod", int'(minPeriod), ONES);
    chk("R4", "reset inStart", int'(inStart), 0);
    rstN = 1;
    @(negedge clk);

    wrData = 8'd5; wrModulus = 1; tickc("R2");
    enable = 1; tickc("R4");
    runClk("R1", 2, 6);
    chk("R1", "period of 4-cycle word clock", int'(periodOut), 4);
    chk("R2", "six edges modulo 5", int'(wordCount), 1);

    runClk("R7", 3, 2);
    runClk("R7", 1, 3);
    runClk("R7", 3, 2);
    chk("R7", "minimum kept", int'(minPeriod), 2);
    chk("R1", "period after change", int'(periodOut), 6);
    wrData = 8'd17; wrMinReset = 1; tickc("R7");
    chk("R7", "minimum reset to all ones", int'(minPeriod), ONES);

    wrData = 8'd3; wrSet = 1; tickc("R5");
    chk("R5", "set loads value", int'(wordCount), 3);
    wrData = 8'd4; wrAdd = 1; tickc("R6");
    chk("R6", "3+4 modulo 5", int'(wordCount), 2);
    wrData = 8'd4; wrSet = 1; tickc("R5");
    wordClk = 1; wrData = 8'd3; wrAdd = 1; tickc("R6");
    chk("R6", "add with coincident edge", int'(wordCount), 3);
    wordClk = 0; tickc("R6"); tickc("R6");

    a = int'(refCount); b = int'(wordCount);
    eventPulse = 1; tickc("R3");
    chk("R3", "captured sub-period", int'(captRef), a);
    chk("R3", "captured frame", int'(captWord), b);

    a = int'(refCount);
    rdWordCnt = 1; tickc("R9");
    chk("R9", "latched sub-period", int'(refLatched), a);

    s0 = nInStart; s1 = nOutStart;
    wrData = 8'd1; wrInTrig = 1; tickc("R8");
    wrData = 8'd4; wrOutTrig = 1; tickc("R8");
    armIn = 1; armOut = 1; tickc("R8");
    chk("R8", "input armed", int'(inReady), 1);
    runClk("R8", 2, 12);
    chk("R8", "input starts once", nInStart - s0, 1);
    chk("R8", "output starts once", nOutStart - s1, 1);
    chk("R8", "ready dropped", int'(inReady) + int'(outReady), 0);

    wrData = 8'd0; wrModulus = 1; tickc("R2");
    wrData = 8'd250; wrSet = 1; tickc("R5");
    runClk("R2", 1, 7);
    chk("R2", "modulus 0 wraps at 256", int'(wordCount), 1);

    enable = 0; tickc("R4");
    eventPulse = 1; wrData = 8'd9; wrSet = 1; tickc("R4");
    chk("R4", "disabled frame count", int'(wordCount), 0);
    chk("R4", "disabled capture", int'(captRef), 0);
    chk("R4", "disabled minimum", int'(minPeriod), ONES);
    enable = 1; tickc("R4");

    // random phase against the model
    wrData = 8'd12; wrModulus = 1; tickc("R2");
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 3 == 0) wordClk = ~wordClk;
      wrData = TW'($urandom % modOf(mModReg));
      if ($urandom % 16 == 0) wrSet = 1;
      if ($urandom % 16 == 0) wrAdd = 1;
      if ($urandom % 16 == 0) eventPulse = 1;
      if ($urandom % 16 == 0) rdWordCnt = 1;
      if ($urandom % 40 == 0) wrMinReset = 1;
      if ($urandom % 30 == 0) armIn = 1;
      if ($urandom % 30 == 0) armOut = 1;
      if ($urandom % 50 == 0) wrInTrig = 1;
      if ($urandom % 50 == 0) wrOutTrig = 1;
      if ($urandom % 300 == 0) begin wrModulus = 1; wrData = TW'(1 + $urandom % 20); end
      if ($urandom % 250 == 0) enable = ~enable;
      else if (!enable && $urandom % 8 == 0) enable = 1;
      tickc("R1 R2 R3 R5 R6 R7 R8 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule